// File: doc/BRIEF.md
# Mailbox Host Register Interface

This block is the host-facing side of a block-transfer management mailbox. A host sees three byte-wide registers: a control/status byte holding the busy and attention handshake flags, a data port, and an interrupt mask/status byte. Bytes the host writes to the data port fill a request buffer. Bytes the host reads from the data port drain a response buffer.

A back end on the other side reads the request buffer through its own read port. It writes the response buffer byte by byte and then loads a length to hand the response over. The host starts a transfer by writing the host-to-controller attention bit. The block answers by setting controller busy and sending a single-cycle request-ready pulse to the back end. Loading a response clears controller busy and raises controller-to-host attention. A separate software-attention input and a cold-reset input also act on the attention and interrupt state. A single level-type interrupt line reports the pending state.

All host accesses complete in one cycle. Read data appears on `host_rdata` in the cycle after the read strobe. State changes from writes, response loads, the attention input and cold reset are visible in the cycle after the clock edge that takes them.

Top module: `mbx_host_regs`

## Requirements
- R1: After the synchronous reset, these values hold: `host_rdata` = 0x00, `irq` = 0, `req_ready` = 0 and `req_count` = 0. The control byte reads 0x00, the mask byte reads 0x00, and a data-port read returns 0xFF.
- R2: The registers sit at offsets 0 (control), 1 (data) and 2 (mask). A read at offset 3 returns 0xFF. A write at offset 3 changes no register.
- R3: A control write with bit 2 set makes `req_ready` high for exactly the next cycle and sets controller busy (control bit 7).
- R4: A control write with bit 0 set zeroes the request count. Bit 1 set zeroes the response read pointer. Bit 3 set clears controller-to-host attention (control bit 3). Bit 4 set clears software attention (control bit 4). Bit 6 set toggles host busy (control bit 6). Control bits 0, 1, 2 and 5 always read 0.
- R5: A data write stores its byte at index `req_count` only while `req_count` < DEPTH. `req_count` increments on every data write, including writes whose byte is dropped. It saturates at 2^CW-1.
- R6: A data read returns the response byte at the read pointer while the pointer is below the response length, then advances the pointer. Reading the last byte zeroes both the pointer and the length. A read with nothing pending returns 0xFF.
- R7: A response load sets the response length to min(`rsp_len`, DEPTH), clears controller busy and sets controller-to-host attention. It sets pending only if the enable is 1 and pending is 0.
- R8: In the mask byte, bit 0 is the enable and bit 1 is pending. Changing the enable from 0 to 1 sets pending when controller-to-host or software attention is set. Changing it from 1 to 0 clears pending.
- R9: A mask write with bit 1 set clears pending if it is set.
- R10: A rising `sms_atn` sets software attention if it is clear, and then sets pending when the enable is 1 and controller-to-host attention is clear. A falling `sms_atn` clears software attention if it is set, and then clears pending when controller-to-host attention is clear. An edge that matches the current flag does nothing.
- R11: `cold_rst` clears the enable and pending, which drops `irq`.
- R12: `irq` equals the pending bit, and `irq` is never high while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cold_rst | input | 1 | Cold reset of interrupt enable and pending |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| irq | output | 1 | Level interrupt to host |
| req_ready | output | 1 | One-cycle request handoff pulse |
| req_count | output | CW | Request bytes written since last clear |
| req_rd_addr | input | AW | Back-end request buffer read address |
| req_rd_data | output | 8 | Request byte, one cycle after address |
| rsp_wr | input | 1 | Back-end response byte write strobe |
| rsp_wr_addr | input | AW | Response byte index |
| rsp_wr_data | input | 8 | Response byte |
| rsp_load | input | 1 | Hand the loaded response to the host |
| rsp_len | input | LW | Response length in bytes |
| sms_atn | input | 1 | Software attention level from the back end |

## Verification
The bench builds the block with DEPTH = 8. With that setting, request overrun beyond the buffer takes only nine writes, and saturation of the 5-bit request count at 31 takes a few dozen. Response lengths above the buffer size can be driven through the 4-bit length port to exercise clamping. A small depth also makes every response short enough that random reads often drain it completely, so the rules that zero the pointer and length and return 0xFF on an empty port are exercised many times.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [1:0] OFS_CTL  = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;

  localparam int CB_CLR_WR = 0;
  localparam int CB_CLR_RD = 1;
  localparam int CB_H2B    = 2;
  localparam int CB_B2H    = 3;
  localparam int CB_SMS    = 4;
  localparam int CB_HBUSY  = 6;
  localparam int CB_BBUSY  = 7;

  localparam int MB_EN   = 0;
  localparam int MB_PEND = 1;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef struct packed {
    logic bbusy;
    logic hbusy;
    logic sms;
    logic b2h;
  } ctl_flags_t;

  function automatic logic [7:0] pack_ctl(input ctl_flags_t f);
    logic [7:0] b;
    b = '0;
    b[CB_BBUSY] = f.bbusy;
    b[CB_HBUSY] = f.hbusy;
    b[CB_SMS]   = f.sms;
    b[CB_B2H]   = f.b2h;
    return b;
  endfunction

  function automatic logic [7:0] pack_mask(input logic en, input logic pend);
    logic [7:0] b;
    b = '0;
    b[MB_EN]   = en;
    b[MB_PEND] = pend;
    return b;
  endfunction
endpackage

// File: rtl/mbx_req_buf.sv
module mbx_req_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_CAP = CW'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       room;

  assign room = (count < CNT_CAP);

  always_ff @(posedge clk) begin
    if (push && room) mem[count[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                    count <= '0;
    else if (push && count != CNT_MAX) count <= count + CW'(1);
  end
endmodule

// File: rtl/mbx_rsp_buf.sv
module mbx_rsp_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          load,
  input  logic [LW-1:0] load_len,
  input  logic          clr_ptr,
  input  logic          pop,
  output logic [7:0]    pop_data,
  output logic          avail
);
  localparam logic [LW-1:0] LEN_CAP = LW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] ptr;
  logic [LW-1:0] len;
  logic          take;

  assign avail = (ptr < len);
  assign take  = pop && avail;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (take) pop_data <= mem[ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      len <= '0;
    end else begin
      if (take) begin
        if (ptr + LW'(1) == len) begin
          ptr <= '0;
          len <= '0;
        end else begin
          ptr <= ptr + LW'(1);
        end
      end
      if (clr_ptr) ptr <= '0;
      if (load)    len <= (load_len > LEN_CAP) ? LEN_CAP : load_len;
    end
  end
endmodule

// File: rtl/mbx_ctl_irq.sv
module mbx_ctl_irq
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cold_rst,
  input  logic       ctl_we,
  input  logic       w_h2b,
  input  logic       w_b2h_clr,
  input  logic       w_sms_clr,
  input  logic       w_hbusy_tgl,
  input  logic       mask_we,
  input  logic       w_en,
  input  logic       w_pend_clr,
  input  logic       rsp_load,
  input  logic       sms_in,
  output logic [7:0] ctl_byte,
  output logic [7:0] mask_byte,
  output logic       irq,
  output logic       req_ready
);
  ctl_flags_t fl_q, fl_d;
  logic       en_q, en_d;
  logic       pend_q, pend_d;
  logic       sms_prev;
  logic       sms_rise, sms_fall;

  assign sms_rise = sms_in && !sms_prev;
  assign sms_fall = !sms_in && sms_prev;

  always_comb begin
    fl_d   = fl_q;
    en_d   = en_q;
    pend_d = pend_q;
    if (ctl_we) begin
      if (w_b2h_clr)   fl_d.b2h   = 1'b0;
      if (w_sms_clr)   fl_d.sms   = 1'b0;
      if (w_hbusy_tgl) fl_d.hbusy = !fl_d.hbusy;
      if (w_h2b)       fl_d.bbusy = 1'b1;
    end
    if (mask_we) begin
      if (w_en != en_d) begin
        if (w_en) begin
          if (fl_d.b2h || fl_d.sms) pend_d = 1'b1;
          en_d = 1'b1;
        end else begin
          pend_d = 1'b0;
          en_d   = 1'b0;
        end
      end
      if (w_pend_clr && pend_d) pend_d = 1'b0;
    end
    if (sms_rise && !fl_d.sms) begin
      fl_d.sms = 1'b1;
      if (en_d && !fl_d.b2h) pend_d = 1'b1;
    end
    if (sms_fall && fl_d.sms) begin
      fl_d.sms = 1'b0;
      if (!fl_d.b2h && pend_d) pend_d = 1'b0;
    end
    if (rsp_load) begin
      fl_d.bbusy = 1'b0;
      fl_d.b2h   = 1'b1;
      if (en_d && !pend_d) pend_d = 1'b1;
    end
    if (cold_rst) begin
      en_d   = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_q      <= '0;
      en_q      <= 1'b0;
      pend_q    <= 1'b0;
      sms_prev  <= 1'b0;
      req_ready <= 1'b0;
    end else begin
      fl_q      <= fl_d;
      en_q      <= en_d;
      pend_q    <= pend_d;
      sms_prev  <= sms_in;
      req_ready <= ctl_we && w_h2b;
    end
  end

  assign ctl_byte  = pack_ctl(fl_q);
  assign mask_byte = pack_mask(en_q, pend_q);
  assign irq       = pend_q;
endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
  import mbx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 2,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cold_rst,
  input  logic [1:0]    host_addr,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  input  logic          host_rd,
  output logic [7:0]    host_rdata,
  output logic          irq,
  output logic          req_ready,
  output logic [CW-1:0] req_count,
  input  logic [AW-1:0] req_rd_addr,
  output logic [7:0]    req_rd_data,
  input  logic          rsp_wr,
  input  logic [AW-1:0] rsp_wr_addr,
  input  logic [7:0]    rsp_wr_data,
  input  logic          rsp_load,
  input  logic [LW-1:0] rsp_len,
  input  logic          sms_atn
);
  logic       ctl_we, data_we, mask_we, data_rd;
  logic [7:0] ctl_byte, mask_byte;
  logic [7:0] pop_data;
  logic       avail;
  logic       rd_from_mem;
  logic [7:0] rd_byte;

  assign ctl_we  = host_wr && (host_addr == OFS_CTL);
  assign data_we = host_wr && (host_addr == OFS_DATA);
  assign mask_we = host_wr && (host_addr == OFS_MASK);
  assign data_rd = host_rd && (host_addr == OFS_DATA);

  mbx_req_buf #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_req (
    .clk       (clk),
    .rst       (rst),
    .clr       (ctl_we && host_wdata[CB_CLR_WR]),
    .push      (data_we),
    .push_data (host_wdata),
    .rd_addr   (req_rd_addr),
    .rd_data   (req_rd_data),
    .count     (req_count)
  );

  mbx_rsp_buf #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_rsp (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rsp_wr),
    .wr_addr  (rsp_wr_addr),
    .wr_data  (rsp_wr_data),
    .load     (rsp_load),
    .load_len (rsp_len),
    .clr_ptr  (ctl_we && host_wdata[CB_CLR_RD]),
    .pop      (data_rd),
    .pop_data (pop_data),
    .avail    (avail)
  );

  mbx_ctl_irq u_ctl (
    .clk         (clk),
    .rst         (rst),
    .cold_rst    (cold_rst),
    .ctl_we      (ctl_we),
    .w_h2b       (host_wdata[CB_H2B]),
    .w_b2h_clr   (host_wdata[CB_B2H]),
    .w_sms_clr   (host_wdata[CB_SMS]),
    .w_hbusy_tgl (host_wdata[CB_HBUSY]),
    .mask_we     (mask_we),
    .w_en        (host_wdata[MB_EN]),
    .w_pend_clr  (host_wdata[MB_PEND]),
    .rsp_load    (rsp_load),
    .sms_in      (sms_atn),
    .ctl_byte    (ctl_byte),
    .mask_byte   (mask_byte),
    .irq         (irq),
    .req_ready   (req_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_from_mem <= 1'b0;
      rd_byte     <= 8'h00;
    end else if (host_rd) begin
      rd_from_mem <= 1'b0;
      unique case (host_addr)
        OFS_CTL:  rd_byte <= ctl_byte;
        OFS_MASK: rd_byte <= mask_byte;
        OFS_DATA: begin
          rd_from_mem <= avail;
          rd_byte     <= IDLE_BYTE;
        end
        default:  rd_byte <= IDLE_BYTE;
      endcase
    end
  end

  assign host_rdata = rd_from_mem ? pop_data : rd_byte;
endmodule

// File: rtl/mbx_host_regs_chk.sv
module mbx_host_regs_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cold_rst,
  input logic [1:0]    host_addr,
  input logic          host_wr,
  input logic          wr_bit2,
  input logic          host_rd,
  input logic [7:0]    host_rdata,
  input logic          irq,
  input logic          req_ready,
  input logic [CW-1:0] req_count,
  input logic          rsp_load,
  input logic          ctl_b2h,
  input logic          ctl_bbusy,
  input logic          mask_en
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd0 && wr_bit2 && !rsp_load) |=> (req_ready && ctl_bbusy));

  p_idle_read_r2: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 2'd3) |=> (host_rdata == 8'hFF));

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd1 && req_count != CNT_MAX) |=> (req_count == $past(req_count) + CW'(1)));

  p_load_atn_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_load |=> (ctl_b2h && !ctl_bbusy));

  p_cold_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    cold_rst |=> (!irq && !mask_en));

  p_irq_needs_en_r12: assert property (@(posedge clk) disable iff (rst)
    irq |-> mask_en);
endmodule

bind mbx_host_regs mbx_host_regs_chk #(.CW(CW)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .cold_rst   (cold_rst),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .wr_bit2    (host_wdata[2]),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .irq        (irq),
  .req_ready  (req_ready),
  .req_count  (req_count),
  .rsp_load   (rsp_load),
  .ctl_b2h    (ctl_byte[3]),
  .ctl_bbusy  (ctl_byte[7]),
  .mask_en    (mask_byte[0])
);

// File: tb/test_mbx_host_regs.sv
module test_mbx_host_regs;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH   = 8;
  localparam int AW      = 3;
  localparam int CW      = 5;
  localparam int LW      = 4;
  localparam int CNT_MAX = 31;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cold_rst = 1'b0;
  logic [1:0]    host_addr = '0;
  logic          host_wr = 1'b0;
  logic [7:0]    host_wdata = '0;
  logic          host_rd = 1'b0;
  logic [7:0]    host_rdata;
  logic          irq;
  logic          req_ready;
  logic [CW-1:0] req_count;
  logic [AW-1:0] req_rd_addr = '0;
  logic [7:0]    req_rd_data;
  logic          rsp_wr = 1'b0;
  logic [AW-1:0] rsp_wr_addr = '0;
  logic [7:0]    rsp_wr_data = '0;
  logic          rsp_load = 1'b0;
  logic [LW-1:0] rsp_len = '0;
  logic          sms_atn = 1'b0;

  mbx_host_regs #(.DEPTH(DEPTH)) i_mbx_host_regs (
    .clk(clk), .rst(rst), .cold_rst(cold_rst),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .irq(irq), .req_ready(req_ready), .req_count(req_count),
    .req_rd_addr(req_rd_addr), .req_rd_data(req_rd_data),
    .rsp_wr(rsp_wr), .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data),
    .rsp_load(rsp_load), .rsp_len(rsp_len), .sms_atn(sms_atn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_bad    = 0;

  bit m_hbusy, m_bbusy, m_b2h, m_sms, m_en, m_pend, m_sms_in;
  int m_cnt, m_ptr, m_len;
  logic [7:0] m_req [DEPTH];
  logic [7:0] m_rsp [DEPTH];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctl();
    return {m_bbusy, m_hbusy, 1'b0, m_sms, m_b2h, 3'b000};
  endfunction

  function automatic logic [7:0] exp_mask();
    return {6'b0, m_pend, m_en};
  endfunction

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    case (a)
      2'd0: begin
        if (d[0]) m_cnt = 0;
        if (d[1]) m_ptr = 0;
        if (d[3]) m_b2h = 0;
        if (d[4]) m_sms = 0;
        if (d[6]) m_hbusy = !m_hbusy;
        if (d[2]) m_bbusy = 1;
      end
      2'd1: begin
        if (m_cnt < DEPTH) m_req[m_cnt] = d;
        if (m_cnt < CNT_MAX) m_cnt++;
      end
      2'd2: begin
        if (d[0] != m_en) begin
          if (d[0]) begin
            if (m_b2h || m_sms) m_pend = 1;
            m_en = 1;
          end else begin
            m_pend = 0;
            m_en = 0;
          end
        end
        if (d[1] && m_pend) m_pend = 0;
      end
      default: ;
    endcase
    chk("R3 req_ready", 32'(req_ready), 32'(a == 2'd0 && d[2]));
    chk("R12 irq", 32'(irq), 32'(m_pend));
    chk("R5 req_count", 32'(req_count), 32'(m_cnt));
  endtask

  task automatic host_read(input logic [1:0] a, input string req);
    logic [7:0] exp;
    case (a)
      2'd0: exp = exp_ctl();
      2'd2: exp = exp_mask();
      2'd1: begin
        if (m_ptr < m_len) begin
          exp = m_rsp[m_ptr];
          m_ptr++;
          if (m_ptr == m_len) begin m_ptr = 0; m_len = 0; end
        end else exp = 8'hFF;
      end
      default: exp = 8'hFF;
    endcase
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk(req, 32'(host_rdata), 32'(exp));
  endtask

  task automatic load_rsp(input int len, input int base);
    int n;
    n = (len > DEPTH) ? DEPTH : len;
    for (int i = 0; i < n; i++) begin
      rsp_wr = 1'b1; rsp_wr_addr = AW'(i); rsp_wr_data = 8'(base + i * 7);
      m_rsp[i] = 8'(base + i * 7);
      @(negedge clk);
    end
    rsp_wr = 1'b0;
    rsp_len = LW'(len); rsp_load = 1'b1;
    @(negedge clk);
    rsp_load = 1'b0;
    m_len = n;
    m_bbusy = 0; m_b2h = 1;
    if (m_en && !m_pend) m_pend = 1;
    chk("R7 irq after load", 32'(irq), 32'(m_pend));
  endtask

  task automatic set_sms(input bit v);
    sms_atn = v;
    @(negedge clk);
    if (v != m_sms_in) begin
      if (v) begin
        if (!m_sms) begin m_sms = 1; if (m_en && !m_b2h) m_pend = 1; end
      end else begin
        if (m_sms) begin m_sms = 0; if (!m_b2h && m_pend) m_pend = 0; end
      end
      m_sms_in = v;
    end
    chk("R10 irq after attention edge", 32'(irq), 32'(m_pend));
  endtask

  task automatic cold();
    cold_rst = 1'b1;
    @(negedge clk);
    cold_rst = 1'b0;
    m_en = 0; m_pend = 0;
    chk("R11 irq after cold reset", 32'(irq), 32'(0));
  endtask

  task automatic peek_req(input int i);
    req_rd_addr = AW'(i);
    @(negedge clk);
    chk("R5 stored request byte", 32'(req_rd_data), 32'(m_req[i]));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int op;
    void'($urandom(32'h1b7e));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", 32'(host_rdata), 32'h00);
    chk("R1 irq", 32'(irq), 32'(0));
    chk("R1 req_ready", 32'(req_ready), 32'(0));
    chk("R1 req_count", 32'(req_count), 32'(0));
    host_read(2'd0, "R1 control");
    host_read(2'd2, "R1 mask");
    host_read(2'd1, "R1 empty data");

    // R2 unused offset
    host_read(2'd3, "R2 offset3 read");
    host_write(2'd3, 8'hFF);
    host_read(2'd0, "R2 control after offset3 write");
    host_read(2'd2, "R2 mask after offset3 write");

    // R5 overrun and saturation
    for (int i = 0; i < DEPTH + 3; i++) host_write(2'd1, 8'(8'h30 + i));
    for (int i = 0; i < DEPTH; i++) peek_req(i);
    for (int i = 0; i < 25; i++) host_write(2'd1, 8'hA5);
    chk("R5 saturated count", 32'(req_count), 32'(CNT_MAX));
    for (int i = 0; i < DEPTH; i++) peek_req(i);
    host_write(2'd0, 8'h01);
    chk("R4 count cleared", 32'(req_count), 32'(0));

    // R3 handoff
    host_write(2'd0, 8'h04);
    host_read(2'd0, "R3 controller busy set");

    // R7 load with interrupt enabled
    host_write(2'd2, 8'h01);
    chk("R8 no attention no pending", 32'(irq), 32'(0));
    load_rsp(3, 8'h11);
    chk("R7 irq raised", 32'(irq), 32'(1));
    host_read(2'd0, "R7 control after load");

    // R6 draining
    for (int i = 0; i < 4; i++) host_read(2'd1, "R6 data read");
    load_rsp(2, 8'h50);
    host_read(2'd1, "R6 first byte");
    host_write(2'd0, 8'h02);
    host_read(2'd1, "R4 rewind read pointer");
    host_read(2'd1, "R6 last byte");
    host_read(2'd1, "R6 empty after drain");
    load_rsp(11, 8'h70);
    for (int i = 0; i < DEPTH + 1; i++) host_read(2'd1, "R7 clamped length read");

    // R9 pending clear
    host_write(2'd2, 8'h03);
    chk("R9 pending cleared", 32'(irq), 32'(0));
    host_read(2'd2, "R9 mask after clear");

    // R8 enable transitions
    host_write(2'd2, 8'h00);
    host_write(2'd2, 8'h01);
    chk("R8 enable with attention", 32'(irq), 32'(1));
    host_write(2'd2, 8'h00);
    chk("R8 disable clears", 32'(irq), 32'(0));

    // R4 toggles and clears
    host_write(2'd0, 8'h40);
    host_read(2'd0, "R4 host busy on");
    host_write(2'd0, 8'h40);
    host_write(2'd0, 8'h08);
    host_read(2'd0, "R4 busy off and attention cleared");

    // R10 software attention
    host_write(2'd2, 8'h01);
    set_sms(1'b1);
    chk("R10 rise raises irq", 32'(irq), 32'(1));
    host_read(2'd0, "R10 flag set");
    set_sms(1'b0);
    chk("R10 fall lowers irq", 32'(irq), 32'(0));
    load_rsp(1, 8'h22);
    host_write(2'd2, 8'h03);
    set_sms(1'b1);
    chk("R10 no irq while b2h set", 32'(irq), 32'(0));
    host_write(2'd0, 8'h10);
    host_read(2'd0, "R4 software attention cleared");
    set_sms(1'b0);
    host_read(2'd0, "R10 repeat ignored");

    // R11 cold reset
    host_write(2'd2, 8'h00);
    host_write(2'd2, 8'h01);
    chk("R11 pending before cold", 32'(irq), 32'(1));
    cold();
    host_read(2'd2, "R11 mask after cold");

    // random phase
    for (int k = 0; k < 800; k++) begin
      op = int'($urandom_range(0, 99));
      if (op < 40)      host_write(2'($urandom_range(0, 3)), 8'($urandom()));
      else if (op < 75) host_read(2'($urandom_range(0, 3)), "R6 random read");
      else if (op < 85) load_rsp(int'($urandom_range(0, DEPTH + 3)), int'($urandom_range(0, 255)));
      else if (op < 95) set_sms(!m_sms_in);
      else              cold();
    end

    summary();
    $finish;
  end
endmodule